// File: doc/BRIEF.md
# Multiplexed Nibble Bus Cycle Sequencer

This block is the bus-side timing unit of a small 4-bit processor. It divides time into machine cycles of eight clocks. The 12-bit program address is sent over one shared 4-bit bus as three nibbles, least significant first. The bus is then released so that the selected program memory can return an 8-bit instruction as two nibbles, high nibble first. The last three slots of each cycle are left to the execution logic, which is not part of this block.

A sync pulse marks the slot just before the first address nibble, so that external latches can align to the cycle. The block also drives the memory select lines. Two program-memory chip selects extend the program space to 13 bits; exactly one of them is active at any time. Four data-memory bank selects work one-of-four. The program address and both bank codes are captured once per cycle, at the boundary between cycles. A change on those inputs in the middle of a cycle therefore only takes effect in the next one.

Top module: `nibble_bus_seq`

## Requirements
- R1: While reset is held: `sync_o`=1, `bus_oe`=0, `bus_out`=0, `instr_vld`=0, `instr_o`=0, `rom_cs`=2'b01 and `ram_cs`=4'b0001.
- R2: Slots are numbered 0 to 7, and the clock period after reset is released is slot 7. `sync_o` is high during slot 7 and low in every other slot, so it pulses once every 8 clocks.
- R3: In slots 0, 1 and 2, `bus_oe`=1. `bus_out` carries bits [3:0], [7:4] and [11:8] respectively of the `pc_in` value captured at the rising edge that ends slot 7.
- R4: In slots 3 to 7, `bus_oe`=0 and `bus_out`=0.
- R5: `bus_in` is captured into `instr_o[7:4]` at the edge that ends slot 3, and into `instr_o[3:0]` at the edge that ends slot 4. `instr_vld` is high during slot 5 only. `instr_o` holds its value until the next fetch.
- R6: `rom_cs` is one-hot. Bank code 0 gives 2'b01 and bank code 1 gives 2'b10.
- R7: `ram_cs` is one-hot, with bit k set for bank code k (0 to 3).
- R8: `rom_bank_in` and `ram_bank_in` are sampled only at the edge that ends slot 7. A change at any other time has no effect on `rom_cs` or `ram_cs` until the next cycle.
- R9: A change on `pc_in` after the cycle has started does not alter the address nibbles driven in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pc_in | input | 12 | Program address for the next cycle |
| rom_bank_in | input | 1 | Program-memory bank code |
| ram_bank_in | input | 2 | Data-memory bank code |
| bus_in | input | 4 | Nibble read from the shared bus |
| bus_out | output | 4 | Nibble driven onto the shared bus |
| bus_oe | output | 1 | Bus driver enable (0 = high impedance) |
| sync_o | output | 1 | Cycle alignment pulse |
| rom_cs | output | 2 | One-hot program-memory chip selects |
| ram_cs | output | 4 | One-hot data-memory bank selects |
| instr_o | output | 8 | Fetched instruction byte |
| instr_vld | output | 1 | One-clock strobe for a new instruction |

## Verification
The checker compares the slot-timed outputs against its own free-running slot counter on every cycle. It checks the sync period, the driver-enable window and the position of the instruction strobe. It also checks that both select groups stay one-hot and change only at a cycle boundary. The bench scenarios cover the data-dependent parts. These are the order and value of each address nibble, which instruction nibble lands where, and the fact that mid-cycle changes to the address or bank codes leave the current cycle untouched.

// File: rtl/nbs_pkg.sv
package nbs_pkg;

  typedef enum logic [1:0] {
    PH_ADDR = 2'd0,
    PH_READ = 2'd1,
    PH_EXEC = 2'd2
  } phase_e;

  // Classify a slot number into its bus phase.
  function automatic phase_e phase_of(input int slot, input int addr_nibs,
                                      input int instr_nibs);
    if (slot < addr_nibs)                   return PH_ADDR;
    else if (slot < addr_nibs + instr_nibs) return PH_READ;
    else                                    return PH_EXEC;
  endfunction

endpackage

// File: rtl/nbs_slot_counter.sv
module nbs_slot_counter #(
  parameter int SLOTS = 8,
  localparam int SW = $clog2(SLOTS)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [SW-1:0] slot_q,
  output logic          cyc_end
);

  localparam logic [SW-1:0] LAST = SW'(SLOTS - 1);

  always_ff @(posedge clk) begin
    if (!rst_n)              slot_q <= LAST;
    else if (slot_q == LAST) slot_q <= '0;
    else                     slot_q <= slot_q + 1'b1;
  end

  assign cyc_end = (slot_q == LAST);

endmodule

// File: rtl/nbs_addr_drive.sv
module nbs_addr_drive #(
  parameter int NIB_W     = 4,
  parameter int ADDR_NIBS = 3,
  parameter int SLOTS     = 8,
  localparam int SW   = $clog2(SLOTS),
  localparam int PC_W = NIB_W * ADDR_NIBS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [PC_W-1:0]  pc_in,
  input  logic [SW-1:0]    slot,
  output logic [NIB_W-1:0] bus_out,
  output logic             bus_oe
);

  logic [PC_W-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    addr_q <= '0;
    else if (load) addr_q <= pc_in;
  end

  // Pick the nibble of the held address that belongs to the current slot.
  function automatic logic [NIB_W-1:0] nib_for_slot(input logic [PC_W-1:0] a,
                                                    input logic [SW-1:0] s);
    logic [NIB_W-1:0] r;
    r = '0;
    for (int i = 0; i < ADDR_NIBS; i++)
      if (s == SW'(i)) r = a[i*NIB_W +: NIB_W];
    return r;
  endfunction

  assign bus_oe  = rst_n && (slot < SW'(ADDR_NIBS));
  assign bus_out = bus_oe ? nib_for_slot(addr_q, slot) : '0;

endmodule

// File: rtl/nbs_fetch_capture.sv
module nbs_fetch_capture #(
  parameter int NIB_W      = 4,
  parameter int INSTR_NIBS = 2,
  parameter int FIRST_RD   = 3,
  parameter int SLOTS      = 8,
  localparam int SW      = $clog2(SLOTS),
  localparam int INSTR_W = NIB_W * INSTR_NIBS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [SW-1:0]      slot,
  input  logic [NIB_W-1:0]   bus_in,
  output logic [INSTR_W-1:0] instr_o,
  output logic               instr_vld
);

  localparam logic [SW-1:0] LAST_RD = SW'(FIRST_RD + INSTR_NIBS - 1);

  logic [NIB_W-1:0] nib_q [INSTR_NIBS];

  // The k-th read slot fills the k-th nibble counted from the top.
  for (genvar k = 0; k < INSTR_NIBS; k++) begin : g_nib
    always_ff @(posedge clk) begin
      if (!rst_n)                      nib_q[k] <= '0;
      else if (slot == SW'(FIRST_RD + k)) nib_q[k] <= bus_in;
    end
    assign instr_o[(INSTR_NIBS-1-k)*NIB_W +: NIB_W] = nib_q[k];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) instr_vld <= 1'b0;
    else        instr_vld <= (slot == LAST_RD);
  end

endmodule

// File: rtl/nbs_sel_decode.sv
module nbs_sel_decode #(
  parameter int N = 4,
  localparam int CW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] code,
  output logic [N-1:0]  cs
);

  logic [N-1:0] dec;

  for (genvar g = 0; g < N; g++) begin : g_dec
    assign dec[g] = (code == CW'(g));
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    cs <= N'(1);
    else if (load) cs <= dec;
  end

endmodule

// File: rtl/nibble_bus_seq.sv
module nibble_bus_seq #(
  parameter int NIB_W      = 4,
  parameter int ADDR_NIBS  = 3,
  parameter int INSTR_NIBS = 2,
  parameter int SLOTS      = 8,
  parameter int ROM_BANKS  = 2,
  parameter int RAM_BANKS  = 4,
  localparam int PC_W      = NIB_W * ADDR_NIBS,
  localparam int INSTR_W   = NIB_W * INSTR_NIBS,
  localparam int ROM_SEL_W = $clog2(ROM_BANKS),
  localparam int RAM_SEL_W = $clog2(RAM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [PC_W-1:0]      pc_in,
  input  logic [ROM_SEL_W-1:0] rom_bank_in,
  input  logic [RAM_SEL_W-1:0] ram_bank_in,
  input  logic [NIB_W-1:0]     bus_in,
  output logic [NIB_W-1:0]     bus_out,
  output logic                 bus_oe,
  output logic                 sync_o,
  output logic [ROM_BANKS-1:0] rom_cs,
  output logic [RAM_BANKS-1:0] ram_cs,
  output logic [INSTR_W-1:0]   instr_o,
  output logic                 instr_vld
);
  import nbs_pkg::*;

  localparam int SW = $clog2(SLOTS);

  logic [SW-1:0] slot_q;
  logic          cyc_end;
  phase_e        phase;
  logic          addr_phase;
  logic          read_phase;

  nbs_slot_counter #(.SLOTS(SLOTS)) u_slot (
    .clk     (clk),
    .rst_n   (rst_n),
    .slot_q  (slot_q),
    .cyc_end (cyc_end)
  );

  assign phase      = phase_of(int'(slot_q), ADDR_NIBS, INSTR_NIBS);
  assign addr_phase = (phase == PH_ADDR);
  assign read_phase = (phase == PH_READ);
  assign sync_o     = cyc_end;

  nbs_addr_drive #(
    .NIB_W(NIB_W), .ADDR_NIBS(ADDR_NIBS), .SLOTS(SLOTS)
  ) u_addr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (cyc_end),
    .pc_in   (pc_in),
    .slot    (slot_q),
    .bus_out (bus_out),
    .bus_oe  (bus_oe)
  );

  nbs_fetch_capture #(
    .NIB_W(NIB_W), .INSTR_NIBS(INSTR_NIBS), .FIRST_RD(ADDR_NIBS), .SLOTS(SLOTS)
  ) u_fetch (
    .clk       (clk),
    .rst_n     (rst_n),
    .slot      (slot_q),
    .bus_in    (bus_in),
    .instr_o   (instr_o),
    .instr_vld (instr_vld)
  );

  nbs_sel_decode #(.N(ROM_BANKS)) u_rom_sel (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (cyc_end),
    .code  (rom_bank_in),
    .cs    (rom_cs)
  );

  nbs_sel_decode #(.N(RAM_BANKS)) u_ram_sel (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (cyc_end),
    .code  (ram_bank_in),
    .cs    (ram_cs)
  );

endmodule

// File: rtl/nbs_checker.sv
module nbs_checker #(
  parameter int ADDR_NIBS  = 3,
  parameter int INSTR_NIBS = 2,
  parameter int SLOTS      = 8,
  parameter int ROM_BANKS  = 2,
  parameter int RAM_BANKS  = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bus_oe,
  input logic                 sync_o,
  input logic                 instr_vld,
  input logic [ROM_BANKS-1:0] rom_cs,
  input logic [RAM_BANKS-1:0] ram_cs
);
  localparam int CW = $clog2(SLOTS);

  logic [CW-1:0] cnt;
  always_ff @(posedge clk) begin
    if (!rst_n)                       cnt <= CW'(SLOTS - 1);
    else if (cnt == CW'(SLOTS - 1))   cnt <= '0;
    else                              cnt <= cnt + 1'b1;
  end

  // R2
  sync_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_o == (cnt == CW'(SLOTS - 1)));

  // R3
  drive_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe == (cnt < CW'(ADDR_NIBS)));

  // R4
  read_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    instr_vld |-> !bus_oe);

  // R5
  fetch_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    instr_vld == (cnt == CW'(ADDR_NIBS + INSTR_NIBS)));

  // R6
  rom_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rom_cs) == 1);

  // R7
  ram_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(ram_cs) == 1);

  // R8
  sel_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({rom_cs, ram_cs}) |-> $past(sync_o));

endmodule

bind nibble_bus_seq nbs_checker #(
  .ADDR_NIBS(ADDR_NIBS), .INSTR_NIBS(INSTR_NIBS), .SLOTS(SLOTS),
  .ROM_BANKS(ROM_BANKS), .RAM_BANKS(RAM_BANKS)
) u_nbs_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_oe    (bus_oe),
  .sync_o    (sync_o),
  .instr_vld (instr_vld),
  .rom_cs    (rom_cs),
  .ram_cs    (ram_cs)
);

// File: tb/nibble_bus_seq_bench.sv
`timescale 1ns/1ps
module nibble_bus_seq_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] pc_in = '0;
  logic        rom_bank_in = 1'b0;
  logic [1:0]  ram_bank_in = '0;
  logic [3:0]  bus_in = '0;
  logic [3:0]  bus_out;
  logic        bus_oe, sync_o, instr_vld;
  logic [1:0]  rom_cs;
  logic [3:0]  ram_cs;
  logic [7:0]  instr_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  nibble_bus_seq u_nibble_bus_seq (
    .clk(clk), .rst_n(rst_n), .pc_in(pc_in), .rom_bank_in(rom_bank_in),
    .ram_bank_in(ram_bank_in), .bus_in(bus_in), .bus_out(bus_out),
    .bus_oe(bus_oe), .sync_o(sync_o), .rom_cs(rom_cs), .ram_cs(ram_cs),
    .instr_o(instr_o), .instr_vld(instr_vld)
  );

  function automatic logic [3:0] want_nib(input logic [11:0] pc, input int idx);
    return 4'((pc >> (4 * idx)) & 12'hF);
  endfunction

  function automatic logic [1:0] want_rom(input logic b);
    return b ? 2'b10 : 2'b01;
  endfunction

  function automatic logic [3:0] want_ram(input logic [1:0] c);
    logic [3:0] r;
    r = '0;
    r[c] = 1'b1;
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Enters and leaves at a falling edge inside slot 7.
  task automatic run_cycle(input logic [11:0] pc, input logic rb,
                           input logic [1:0] mb, input logic [7:0] ins);
    logic [7:0] prev_ins;
    check(sync_o == 1'b1, "R2 sync in slot 7", 32'(sync_o), 32'd1);
    pc_in = pc; rom_bank_in = rb; ram_bank_in = mb;
    @(negedge clk); // slot 0
    check(sync_o == 1'b0, "R2 sync low slot 0", 32'(sync_o), 32'd0);
    check(bus_oe == 1'b1, "R3 drive slot 0", 32'(bus_oe), 32'd1);
    check(bus_out == want_nib(pc, 0), "R3 low nibble", 32'(bus_out), 32'(want_nib(pc, 0)));
    check(rom_cs == want_rom(rb), "R6 rom select", 32'(rom_cs), 32'(want_rom(rb)));
    check(ram_cs == want_ram(mb), "R7 ram select", 32'(ram_cs), 32'(want_ram(mb)));
    // Disturb inputs mid-cycle; they must not reach this cycle.
    pc_in = ~pc; rom_bank_in = ~rb; ram_bank_in = mb + 2'd1;
    @(negedge clk); // slot 1
    check(bus_out == want_nib(pc, 1), "R9 middle nibble held", 32'(bus_out), 32'(want_nib(pc, 1)));
    check(rom_cs == want_rom(rb), "R8 rom select held", 32'(rom_cs), 32'(want_rom(rb)));
    check(ram_cs == want_ram(mb), "R8 ram select held", 32'(ram_cs), 32'(want_ram(mb)));
    @(negedge clk); // slot 2
    check(bus_oe == 1'b1, "R3 drive slot 2", 32'(bus_oe), 32'd1);
    check(bus_out == want_nib(pc, 2), "R9 high nibble held", 32'(bus_out), 32'(want_nib(pc, 2)));
    @(negedge clk); // slot 3
    check(bus_oe == 1'b0, "R4 release slot 3", 32'(bus_oe), 32'd0);
    check(bus_out == 4'd0, "R4 idle bus slot 3", 32'(bus_out), 32'd0);
    prev_ins = instr_o;
    bus_in = ins[7:4];
    @(negedge clk); // slot 4
    check(bus_oe == 1'b0, "R4 release slot 4", 32'(bus_oe), 32'd0);
    check(instr_vld == 1'b0, "R5 no strobe slot 4", 32'(instr_vld), 32'd0);
    check(instr_o[7:4] == ins[7:4] && instr_o[3:0] == prev_ins[3:0], "R5 high nibble first",
          32'(instr_o), 32'({ins[7:4], prev_ins[3:0]}));
    bus_in = ins[3:0];
    @(negedge clk); // slot 5
    bus_in = ~ins[3:0];
    check(instr_vld == 1'b1, "R5 strobe slot 5", 32'(instr_vld), 32'd1);
    check(instr_o == ins, "R5 instruction", 32'(instr_o), 32'(ins));
    check(bus_oe == 1'b0, "R4 release slot 5", 32'(bus_oe), 32'd0);
    @(negedge clk); // slot 6
    check(instr_vld == 1'b0, "R5 strobe ends", 32'(instr_vld), 32'd0);
    check(instr_o == ins, "R5 instruction held", 32'(instr_o), 32'(ins));
    check(sync_o == 1'b0, "R2 sync low slot 6", 32'(sync_o), 32'd0);
    @(negedge clk); // slot 7
    check(bus_oe == 1'b0 && bus_out == 4'd0, "R4 idle slot 7", 32'({bus_oe, bus_out}), 32'd0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1 reset state
    check(sync_o == 1'b1, "R1 sync", 32'(sync_o), 32'd1);
    check(bus_oe == 1'b0 && bus_out == 4'd0, "R1 bus idle", 32'({bus_oe, bus_out}), 32'd0);
    check(instr_vld == 1'b0 && instr_o == 8'd0, "R1 fetch idle", 32'({instr_vld, instr_o}), 32'd0);
    check(rom_cs == 2'b01, "R1 rom select", 32'(rom_cs), 32'h1);
    check(ram_cs == 4'b0001, "R1 ram select", 32'(ram_cs), 32'h1);
    rst_n = 1'b1;
    // Directed corners
    run_cycle(12'h000, 1'b0, 2'd0, 8'h00);
    run_cycle(12'hFFF, 1'b1, 2'd3, 8'hFF);
    run_cycle(12'hA5C, 1'b1, 2'd1, 8'h3C);
    run_cycle(12'h123, 1'b0, 2'd2, 8'hC3);
    // Random cycles
    for (int i = 0; i < 40; i++) begin
      run_cycle(12'($urandom), 1'($urandom), 2'($urandom), 8'($urandom));
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule